// File: doc/BRIEF.md
# Scan-Chain Debug Port

This block gives an external host register and memory access to a tiny CPU through four wires. Those wires are a serial clock, a serial data input, a serial data output and a CPU step pulse. Inside the block is a 64-bit shift register clocked by the serial clock. The first serial clock rise after a step pulse (or after reset) copies a snapshot of the CPU state into the register. Every later rise shifts one host bit in, most significant bit first. On the falling edge, the bit at the top of the register moves to the serial output.

After a full scan, the register holds the host's vector. Its top byte is a command, and its two lowest bytes are a 16-bit word. The next step pulse decodes that vector. It can execute the word as an injected instruction, or load the word into the instruction register. The word can load a register with an immediate value, load R1 or R2 from memory at the address in R3, or drive the memory write enable. The CPU state is kept as registers R0 to R3, a program counter and a 16-bit instruction register. Memory is reached only through an address, write-data, write-enable and read-data port.

All four host wires are asynchronous to the core clock. They are synchronized and edge-detected before use.

Top module: `scan_debug_port`

## Requirements
- R1: After reset, R0 to R3, the program counter, the instruction register, `miso_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` are all zero. The first serial rise after reset performs a snapshot load.
- R2: A serial rise while a load is pending replaces the vector with the snapshot and clears the pending flag. Every step pulse sets the flag. The snapshot layout, from the top byte down, is: byte 7 = 0x00, byte 6 = R0, byte 5 = R1, byte 4 = R2, byte 3 = R3, byte 2 = PC, and bytes 1:0 = the instruction register. Register k therefore sits at byte 6-k.
- R3: A serial rise with no pending load shifts the vector left by one bit and puts `mosi_i` into bit 0. `miso_o` takes bit 63 only after a serial fall, so it holds steady while the serial clock is high. A vector scanned in comes back out unchanged, most significant bit first, on the next scan that has no load.
- R4: On a step pulse with command 0x02, a high byte of the form 101iii00 (binary) loads the low byte into the target selected by iii. Index 0 to 3 selects R0 to R3 and index 4 selects the PC. Indices 5 to 7 change nothing.
- R5: On a step pulse with command 0x02, high byte 0xC8 loads R2 from `mem_rdata_i[15:8]`, and high byte 0xC4 loads R1 from `mem_rdata_i[7:0]`. Both reads use `mem_addr_o`.
- R6: `mem_addr_o` always shows R3, and `mem_wdata_o` always shows {R2, R1}. Each step pulse with command 0x02 sets `mem_we_o` to 1 if the high byte is 0x02 and to 0 for any other high byte. No other event changes `mem_we_o`.
- R7: A step pulse with command 0x06 loads the instruction register from bytes 1:0.
- R8: A step pulse with any command other than 0x02 or 0x06 leaves all CPU state and `mem_we_o` unchanged.
- R9: When a serial rise and a step pulse are detected in the same cycle, three things happen. The step decodes the vector as it stood before the shift. The shift or load uses the pending flag and CPU state from before the step. The pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| mosi_i | input | 1 | Serial data from the host (asynchronous) |
| cpu_clk_i | input | 1 | CPU step pulse from the host (asynchronous) |
| miso_o | output | 1 | Serial data to the host |
| mem_addr_o | output | 8 | Memory address, equal to R3 |
| mem_wdata_o | output | 16 | Memory write data, equal to {R2, R1} |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Memory read data at `mem_addr_o` |

## Verification
A step pulse and a serial rise can fall in the same core cycle. In that cycle the step decodes the scan vector while the shifter is overwriting it, and the step sets the load flag while the rise is consuming it. The bench raises `sclk_i` and `cpu_clk_i` on the same clock edge right after scanning in a load-immediate vector. A following scan that loads a snapshot must then show the loaded register. That proves the decode saw the unshifted vector, and that the pending flag survived the rise.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned VEC_BYTES = 8;
  localparam int unsigned VEC_W     = BYTE_W * VEC_BYTES;
  localparam int unsigned WORD_W    = 2 * BYTE_W;
  localparam int unsigned NUM_GPR   = 4;
  localparam int unsigned IDX_W     = 3;

  localparam int unsigned ADDR_GPR = 3;
  localparam int unsigned HI_GPR   = 2;
  localparam int unsigned LO_GPR   = 1;

  localparam logic [BYTE_W-1:0] CMD_EXEC    = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_IR_LOAD = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WE_SET   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_MEM_HI   = 8'hC8;
  localparam logic [BYTE_W-1:0] OP_MEM_LO   = 8'hC4;
  localparam logic [2:0]        OP_LDI_TAG  = 3'b101;
  localparam logic [IDX_W-1:0]  IDX_PC      = 3'd4;

  // field order is the scan order: cmd is shifted out first
  typedef struct packed {
    logic [BYTE_W-1:0] cmd;
    logic [BYTE_W-1:0] r0;
    logic [BYTE_W-1:0] r1;
    logic [BYTE_W-1:0] r2;
    logic [BYTE_W-1:0] r3;
    logic [BYTE_W-1:0] pc;
    logic [BYTE_W-1:0] ir_hi;
    logic [BYTE_W-1:0] ir_lo;
  } scan_vec_t;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbg_scan_shift.sv
module dbg_scan_shift
  import dbg_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic              arm_i,
  input  logic [VEC_W-1:0]  snap_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [WORD_W-1:0] word_o,
  output logic              pend_o,
  output logic              miso_o
);
  logic [VEC_W-1:0] vec_q;
  logic             pend_q;
  logic             miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      pend_q <= 1'b1;
      miso_q <= 1'b0;
    end else begin
      if (shift_i) vec_q <= pend_q ? snap_i : {vec_q[VEC_W-2:0], bit_i};
      // a step arms the next rise for a load; arming wins over consuming
      if (arm_i)        pend_q <= 1'b1;
      else if (shift_i) pend_q <= 1'b0;
      if (fall_i) miso_q <= vec_q[VEC_W-1];
    end
  end

  assign cmd_o  = vec_q[VEC_W-1 -: BYTE_W];
  assign word_o = vec_q[WORD_W-1:0];
  assign pend_o = pend_q;
  assign miso_o = miso_q;
endmodule

// File: rtl/dbg_cpu_core.sv
module dbg_cpu_core
  import dbg_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output scan_vec_t         snap_o,
  output logic [BYTE_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [BYTE_W-1:0] gpr0_o
);
  logic [BYTE_W-1:0] gpr_q [NUM_GPR];
  logic [BYTE_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic              we_q;

  logic [BYTE_W-1:0] op_hi, op_lo;
  logic [IDX_W-1:0]  ldi_idx;
  logic              do_exec, do_ir, is_ldi;

  always_comb begin
    op_hi   = word_i[WORD_W-1:BYTE_W];
    op_lo   = word_i[BYTE_W-1:0];
    ldi_idx = op_hi[4:2];
    is_ldi  = (op_hi[7:5] == OP_LDI_TAG) && (op_hi[1:0] == 2'b00);
    do_exec = step_i && (cmd_i == CMD_EXEC);
    do_ir   = step_i && (cmd_i == CMD_IR_LOAD);
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    logic              wen;
    logic [BYTE_W-1:0] wdat;
    if (g == HI_GPR) begin : g_mem_hi
      always_comb begin
        wen  = do_exec && ((is_ldi && ldi_idx == IDX_W'(g)) || op_hi == OP_MEM_HI);
        wdat = (op_hi == OP_MEM_HI) ? mem_rdata_i[WORD_W-1:BYTE_W] : op_lo;
      end
    end else if (g == LO_GPR) begin : g_mem_lo
      always_comb begin
        wen  = do_exec && ((is_ldi && ldi_idx == IDX_W'(g)) || op_hi == OP_MEM_LO);
        wdat = (op_hi == OP_MEM_LO) ? mem_rdata_i[BYTE_W-1:0] : op_lo;
      end
    end else begin : g_plain
      always_comb begin
        wen  = do_exec && is_ldi && (ldi_idx == IDX_W'(g));
        wdat = op_lo;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  gpr_q[g] <= '0;
      else if (wen) gpr_q[g] <= wdat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      we_q <= 1'b0;
    end else begin
      if (do_exec && is_ldi && ldi_idx == IDX_PC) pc_q <= op_lo;
      if (do_ir)   ir_q <= word_i;
      if (do_exec) we_q <= (op_hi == OP_WE_SET);
    end
  end

  always_comb begin
    snap_o.cmd   = '0;
    snap_o.r0    = gpr_q[0];
    snap_o.r1    = gpr_q[1];
    snap_o.r2    = gpr_q[2];
    snap_o.r3    = gpr_q[3];
    snap_o.pc    = pc_q;
    snap_o.ir_hi = ir_q[WORD_W-1:BYTE_W];
    snap_o.ir_lo = ir_q[BYTE_W-1:0];
  end

  assign mem_addr_o  = gpr_q[ADDR_GPR];
  assign mem_wdata_o = {gpr_q[HI_GPR], gpr_q[LO_GPR]};
  assign mem_we_o    = we_q;
  assign ir_o        = ir_q;
  assign gpr0_o      = gpr_q[0];
endmodule

// File: rtl/scan_debug_port.sv
module scan_debug_port
  import dbg_scan_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        mosi_i,
  input  logic        cpu_clk_i,
  output logic        miso_o,
  output logic [7:0]  mem_addr_o,
  output logic [15:0] mem_wdata_o,
  output logic        mem_we_o,
  input  logic [15:0] mem_rdata_i
);
  localparam int unsigned N_IN    = 3;
  localparam int unsigned IN_SCLK = 0;
  localparam int unsigned IN_MOSI = 1;
  localparam int unsigned IN_CPU  = 2;

  logic [N_IN-1:0] raw_in, lvl;
  assign raw_in = {cpu_clk_i, mosi_i, sclk_i};

  dbg_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (lvl)
  );

  logic sclk_prev_q, cpu_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      cpu_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= lvl[IN_SCLK];
      cpu_prev_q  <= lvl[IN_CPU];
    end
  end

  logic sclk_rise, sclk_fall, cpu_rise;
  assign sclk_rise = lvl[IN_SCLK] & ~sclk_prev_q;
  assign sclk_fall = ~lvl[IN_SCLK] & sclk_prev_q;
  assign cpu_rise  = lvl[IN_CPU] & ~cpu_prev_q;

  scan_vec_t         snap;
  logic [BYTE_W-1:0] cmd_w;
  logic [WORD_W-1:0] word_w, ir_w;
  logic [BYTE_W-1:0] gpr0_w;
  logic              load_pend;

  dbg_scan_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .fall_i (sclk_fall),
    .bit_i  (lvl[IN_MOSI]),
    .arm_i  (cpu_rise),
    .snap_i (snap),
    .cmd_o  (cmd_w),
    .word_o (word_w),
    .pend_o (load_pend),
    .miso_o (miso_o)
  );

  dbg_cpu_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (cpu_rise),
    .cmd_i      (cmd_w),
    .word_i     (word_w),
    .mem_rdata_i(mem_rdata_i),
    .snap_o     (snap),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .ir_o       (ir_w),
    .gpr0_o     (gpr0_w)
  );
endmodule

// File: rtl/scan_debug_port_chk.sv
module scan_debug_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_rise_i,
  input logic        sclk_fall_i,
  input logic        cpu_rise_i,
  input logic        load_pend_i,
  input logic        miso_i,
  input logic        we_i,
  input logic [7:0]  cmd_i,
  input logic [15:0] word_i,
  input logic [15:0] ir_i,
  input logic [7:0]  gpr0_i
);
  // R3
  miso_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_i) |-> $past(sclk_fall_i));

  // R2
  snap_ir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && load_pend_i) |=> (word_i == $past(ir_i)));

  // R2
  step_arms_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rise_i |=> load_pend_i);

  // R4
  gpr_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gpr0_i) |-> $past(cpu_rise_i));

  // R6
  we_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(we_i) |-> $past(cpu_rise_i));

  // R7
  ir_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ir_i) |-> $past(cpu_rise_i && cmd_i == 8'h06));
endmodule

bind scan_debug_port scan_debug_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_rise_i(sclk_rise),
  .sclk_fall_i(sclk_fall),
  .cpu_rise_i (cpu_rise),
  .load_pend_i(load_pend),
  .miso_i     (miso_o),
  .we_i       (mem_we_o),
  .cmd_i      (cmd_w),
  .word_i     (word_w),
  .ir_i       (ir_w),
  .gpr0_i     (gpr0_w)
);

// File: tb/scan_debug_port_test.sv
module scan_debug_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cpu_clk = 1'b0;
  logic miso, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [7:0] a);
    return {a ^ 8'h3C, a + 8'h11};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  scan_debug_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi),
    .cpu_clk_i(cpu_clk), .miso_o(miso), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit r3_bad = 0;

  logic [7:0]  m_r [4];
  logic [7:0]  m_pc;
  logic [15:0] m_ir;
  logic        m_we, m_pend, m_miso;
  logic [63:0] m_vec;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_snap();
    return {8'h00, m_r[0], m_r[1], m_r[2], m_r[3], m_pc, m_ir};
  endfunction

  task automatic m_exec();
    logic [7:0] cmd, hi, lo;
    logic [15:0] rd;
    cmd = m_vec[63:56]; hi = m_vec[15:8]; lo = m_vec[7:0];
    rd  = mem_fn(m_r[3]);
    if (cmd == 8'h06) m_ir = m_vec[15:0];
    else if (cmd == 8'h02) begin
      if (hi[7:5] == 3'b101 && hi[1:0] == 2'b00) begin
        if (hi[4:2] < 3'd4) m_r[hi[3:2]] = lo;
        else if (hi[4:2] == 3'd4) m_pc = lo;
      end
      if (hi == 8'hC8) m_r[2] = rd[15:8];
      if (hi == 8'hC4) m_r[1] = rd[7:0];
      m_we = (hi == 8'h02);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serial_bit(input logic b, output logic got);
    logic hi_val;
    mosi = b;
    wait_n(HOLD);
    got  = miso;
    sclk = 1'b1;
    if (m_pend) begin m_vec = m_snap(); m_pend = 1'b0; end
    else m_vec = {m_vec[62:0], b};
    wait_n(HOLD);
    hi_val = miso;
    if (hi_val !== got) r3_bad = 1;
    sclk = 1'b0;
    wait_n(HOLD);
    m_miso = m_vec[63];
  endtask

  task automatic cpu_pulse();
    cpu_clk = 1'b1;
    m_exec();
    m_pend = 1'b1;
    wait_n(HOLD);
    cpu_clk = 1'b0;
    wait_n(HOLD);
  endtask

  task automatic transact(input bit pre_cpu, input bit pre_spi, input bit scan, input bit post,
                          input logic [63:0] tx, output logic [63:0] rx, output logic [63:0] exp);
    logic g;
    rx = '0; exp = '0;
    if (pre_cpu) cpu_pulse();
    if (pre_spi) serial_bit(1'b0, g);
    if (scan)
      for (int i = 63; i >= 0; i--) begin
        exp[i] = m_miso;
        serial_bit(tx[i], g);
        rx[i] = g;
      end
    if (post) begin cpu_pulse(); serial_bit(1'b0, g); end
  endtask

  task automatic send(input logic [7:0] cmd, input logic [7:0] hi, input logic [7:0] lo);
    logic [63:0] rx, exp;
    transact(1, 1, 1, 0, {cmd, 40'h0, hi, lo}, rx, exp);
  endtask

  task automatic write_reg(input logic [2:0] k, input logic [7:0] v);
    send(8'h02, 8'hA0 | {3'b000, k, 2'b00}, v);
  endtask

  task automatic read_back(input string tag, output logic [63:0] rx);
    logic [63:0] exp;
    transact(1, 1, 1, 0, 64'h0, rx, exp);
    check(rx === exp, tag, rx, exp);
  endtask

  task automatic check_mem(input string tag);
    check(mem_addr === m_r[3], tag, 64'(mem_addr), 64'(m_r[3]));
    check(mem_wdata === {m_r[2], m_r[1]}, tag, 64'(mem_wdata), 64'({m_r[2], m_r[1]}));
    check(mem_we === m_we, tag, 64'(mem_we), 64'(m_we));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] rx, exp;
    logic g;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    m_pc = '0; m_ir = '0; m_we = 0; m_pend = 1; m_miso = 0; m_vec = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state at the ports
    check(miso === 1'b0, "R1 miso", 64'(miso), 0);
    check(mem_we === 1'b0 && mem_addr === 8'h0 && mem_wdata === 16'h0, "R1 mem ports",
          {mem_we, mem_addr, mem_wdata}, 0);
    // R1 first rise after reset loads an all-zero snapshot
    transact(0, 1, 1, 0, 64'h0, rx, exp);
    check(rx === 64'h0, "R1 snapshot", rx, 64'h0);

    // R2 R4 immediate loads and snapshot layout
    write_reg(3'd0, 8'h11); write_reg(3'd1, 8'h22); write_reg(3'd2, 8'h33);
    write_reg(3'd3, 8'h44); write_reg(3'd4, 8'h55);
    read_back("R2 model", rx);
    check(rx === 64'h0011_2233_4455_0000, "R2 layout", rx, 64'h0011_2233_4455_0000);
    check(mem_addr === 8'h44 && mem_wdata === 16'h3322, "R6 addr/data",
          {mem_addr, mem_wdata}, {8'h44, 16'h3322});

    // R4 index 5 is ignored
    write_reg(3'd5, 8'h99);
    read_back("R4 model", rx);
    check(rx === 64'h0011_2233_4455_0000, "R4 idx5 ignored", rx, 64'h0011_2233_4455_0000);

    // R7 instruction register load
    send(8'h06, 8'hBE, 8'hEF);
    read_back("R7 model", rx);
    check(rx === 64'h0011_2233_4455_BEEF, "R7 ir load", rx, 64'h0011_2233_4455_BEEF);

    // R8 other commands are inert
    send(8'h00, 8'hA0, 8'h77);
    send(8'h03, 8'hA0, 8'h77);
    read_back("R8 model", rx);
    check(rx === 64'h0011_2233_4455_BEEF, "R8 inert cmd", rx, 64'h0011_2233_4455_BEEF);

    // R5 memory loads at address R3
    write_reg(3'd3, 8'h10);
    send(8'h02, 8'hC8, 8'h00);
    send(8'h02, 8'hC4, 8'h00);
    read_back("R5 model", rx);
    check(rx === 64'h0011_212C_1055_BEEF, "R5 mem load", rx, 64'h0011_212C_1055_BEEF);

    // R6 write enable set and release
    write_reg(3'd3, 8'h20); write_reg(3'd2, 8'hAB); write_reg(3'd1, 8'hCD);
    send(8'h02, 8'h02, 8'h00);
    read_back("R6 model", rx);
    check({mem_we, mem_addr, mem_wdata} === {1'b1, 8'h20, 16'hABCD}, "R6 we set",
          {mem_we, mem_addr, mem_wdata}, {1'b1, 8'h20, 16'hABCD});
    send(8'h02, 8'h00, 8'h00);
    read_back("R6 model", rx);
    check(mem_we === 1'b0, "R6 we release", 64'(mem_we), 0);

    // R3 loopback without load, MSB first
    transact(0, 0, 1, 0, 64'hF00D_1234_5678_9ABC, rx, exp);
    transact(0, 0, 1, 0, 64'h0123_4567_89AB_CDEF, rx, exp);
    check(rx === 64'hF00D_1234_5678_9ABC, "R3 loopback", rx, 64'hF00D_1234_5678_9ABC);

    // R9 step and serial rise in the same cycle
    transact(0, 0, 1, 0, {8'h02, 40'h0, 8'hA0, 8'h77}, rx, exp);
    mosi = 1'b1;
    wait_n(HOLD);
    begin
      logic old_pend;
      logic [63:0] snap;
      old_pend = m_pend; snap = m_snap();
      sclk = 1'b1; cpu_clk = 1'b1;
      m_exec();
      if (old_pend) m_vec = snap; else m_vec = {m_vec[62:0], 1'b1};
      m_pend = 1'b1;
    end
    wait_n(HOLD);
    sclk = 1'b0; cpu_clk = 1'b0;
    wait_n(HOLD);
    m_miso = m_vec[63];
    transact(0, 1, 1, 0, 64'h0, rx, exp);
    check(rx === exp, "R9 model", rx, exp);
    check(rx[55:48] === 8'h77, "R9 same-cycle decode", 64'(rx[55:48]), 64'h77);

    // random mix
    for (int n = 0; n < 16; n++) begin
      int op;
      op = $urandom_range(0, 4);
      case (op)
        0: write_reg(3'($urandom_range(0, 7)), 8'($urandom));
        1: send(8'h06, 8'($urandom), 8'($urandom));
        2: send(8'h02, ($urandom_range(0, 1) != 0) ? 8'hC8 : 8'hC4, 8'h00);
        3: send(8'h02, ($urandom_range(0, 1) != 0) ? 8'h02 : 8'h00, 8'($urandom));
        default: send(8'($urandom) | 8'h10, 8'hA4, 8'($urandom));
      endcase
      read_back("R4 R5 R7 R8 random", rx);
      check_mem("R6 random");
    end

    serial_bit(1'b0, g);
    check(!r3_bad, "R3 miso steady while sclk high", 64'(r3_bad), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule